// File: doc/BRIEF.md
# Triple Programmable Interval Timer

A three-channel down-counter peripheral sitting on an 8-bit register bus with eight byte offsets. Each channel owns a 16-bit reload latch, a control byte and a running counter. A channel counts either a shared internal tick, produced once every ten system clocks, or its own external clock-enable strobe. It counts either as one 16-bit word or as two cascaded 8-bit halves. Channels run without stopping and reload from their latch on every time-out. Each time-out sets a per-channel flag in the status byte, and the flags, gated by per-channel enables, form a single interrupt line.

Latches are written through a shared high-byte staging register followed by a low-byte write. Counters are read high byte first. That read also snapshots the low byte into a shared holding register, so the two halves always belong to the same count. A flag is cleared by a latch write, by toggling the global reset bit, or by a counter read, but the read clears it only when the status byte was read after the flag was set.

Top module: `tri_interval_timer`

## Requirements
- R1: After rst_ni is released, every latch and counter holds 0xFFFF, every control byte is 0, the status byte reads 0x00, both staging registers are 0, offset 0 reads 0x00 and irq_o is 0.
- R2: Writing offset 1 loads the channel 1 control byte. Writing offset 0 loads the channel 0 control byte when bit 0 of the channel 1 control byte is 1, and the channel 2 control byte otherwise.
- R3: Control bit 1 = 1 makes a channel count an internal tick issued once every 10 clocks. With bit 1 = 0 the channel counts its ext_tick_i bit instead and ignores the internal tick. Any change of bit 1 reloads that channel's counter from its latch.
- R4: Control bit 2 = 1 selects cascaded mode. The low byte decrements per tick. When it is at 0, it reloads from latch[7:0] and the high byte decrements. The channel times out when the high byte is at 0 during that borrow, and the high byte then reloads from latch[15:8]. The period is (latch[15:8]+1)*(latch[7:0]+1) ticks.
- R5: With control bit 2 = 0, the 16-bit counter decrements per tick. When it is at 0, it reloads from the latch and times out, giving a period of latch+1 ticks.
- R6: Writing offset 2, 4 or 6 stores the byte in the staging register. Writing offset 3, 5 or 7 sets the latch of channel (offset-3)/2 to {staging, data} and clears that channel's flag. If control bit 4 is 0, the same write also reloads the counter with the new latch value. If bit 4 is 1, the counter is left as it is.
- R7: Bit 0 of the channel 0 control byte is a global hold. While it is 1, no channel counts. Any change of this bit clears all flags. A 1-to-0 change reloads all three counters from their latches.
- R8: Offset 1 reads the status byte: bits 2..0 are the flags of channels 2..0, bit 7 is the OR over channels of (flag AND control bit 6), and bits 6..3 are 0. irq_o equals status bit 7.
- R9: Reading offset 2, 4 or 6 returns bits 15:8 of the counter of channel (offset-2)/2 and, in the same cycle, captures bits 7:0 into a holding register. Reading offset 3, 5 or 7 returns that holding register.
- R10: A counter high-byte read clears that channel's flag only if a status read happened after the flag was last set. A flag that has not been seen by a status read stays set through counter reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| rd_en_i | input | 1 | Register read strobe; side effects take place at the clock edge |
| addr_i | input | 3 | Register offset 0..7 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i and current state |
| ext_tick_i | input | 3 | Per-channel external clock-enable pulses, synchronous to clk_i |
| irq_o | output | 1 | Composite interrupt, equal to status bit 7 |

## Verification
Most internal faults surface at the ports within one tick of the affected channel. A wrong borrow or reload value changes the counter bytes on the next read, and moves the flag's rise by whole ticks, or by (low latch + 1) ticks in cascaded mode. A lost or stale "seen" marker shows up on the first counter read after a time-out, as a flag that clears when it should stay set or stays set when it should clear. A misrouted control write at offset 0 shows up as the wrong channel changing clock source or entering global hold, which freezes counts that the bench then reads back.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned PRESCALE = 10;

  // control byte bit positions
  localparam int unsigned C_HOLD  = 0;
  localparam int unsigned C_INTCK = 1;
  localparam int unsigned C_DUAL  = 2;
  localparam int unsigned C_NOLD  = 4;
  localparam int unsigned C_IEN   = 6;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/ttm_tick_gen.sv
module ttm_tick_gen #(
  parameter int unsigned DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && DIV > 1) |=> !tick_o);
endmodule

// File: rtl/ttm_channel.sv
module ttm_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         halt_i,
  input  logic         dual_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] latch_i,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  assign step = tick_i && !halt_i && !load_i;

  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (step) begin
      if (dual_i) begin
        if (cnt_q[H-1:0] == '0) begin
          cnt_d[H-1:0] = latch_i[H-1:0];
          if (cnt_q[W-1:H] == '0) begin
            cnt_d[W-1:H] = latch_i[W-1:H];
            expire_o     = 1'b1;
          end else begin
            cnt_d[W-1:H] = cnt_q[W-1:H] - 1'b1;
          end
        end else begin
          cnt_d[H-1:0] = cnt_q[H-1:0] - 1'b1;
        end
      end else if (cnt_q == '0) begin
        cnt_d    = latch_i;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  a_r5_word_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_i && tick_i && !halt_i && !load_i && count_o == '0) |=> count_o == $past(latch_i));

  a_r4_low_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_i && tick_i && !halt_i && !load_i && count_o[H-1:0] == '0)
      |=> count_o[H-1:0] == $past(latch_i[H-1:0]));

  a_r7_hold_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((halt_i || !tick_i) && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import ttm_pkg::*;
#(
  parameter int unsigned DIV = PRESCALE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] ext_tick_i,
  output logic              irq_o
);
  byte_t ctrl_q [NUM_CH];
  cnt_t  latch_q [NUM_CH];
  cnt_t  count [NUM_CH];
  cnt_t  load_val [NUM_CH];
  byte_t msb_q, lsb_q;
  logic [NUM_CH-1:0] flag_q, flag_d, seen_q, seen_d;
  logic [NUM_CH-1:0] expire, load, lat_wr, cnt_rd, ctl_wr, ien;
  logic [NUM_CH-1:0] ch_tick;
  logic int_tick, st_rd, gr_chg, gr_rel;
  logic [1:0] ctl_sel;

  ttm_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(int_tick)
  );

  // offset 0 is shared between channel 0 and channel 2 control
  assign ctl_sel = (addr_i == 3'd1) ? 2'd1 : (ctrl_q[1][0] ? 2'd0 : 2'd2);
  assign st_rd   = rd_en_i && (addr_i == 3'd1);
  assign gr_chg  = ctl_wr[0] && (wdata_i[C_HOLD] != ctrl_q[0][C_HOLD]);
  assign gr_rel  = gr_chg && !wdata_i[C_HOLD];

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      ctl_wr[i] = wr_en_i && (addr_i <= 3'd1) && (ctl_sel == 2'(i));
      lat_wr[i] = wr_en_i && (addr_i == 3'(2 * i + 3));
      cnt_rd[i] = rd_en_i && (addr_i == 3'(2 * i + 2));
      ien[i]    = ctrl_q[i][C_IEN];
      ch_tick[i] = ctrl_q[i][C_INTCK] ? int_tick : ext_tick_i[i];
      load[i]   = gr_rel
                || (ctl_wr[i] && (wdata_i[C_INTCK] != ctrl_q[i][C_INTCK]))
                || (lat_wr[i] && !ctrl_q[i][C_NOLD]);
      load_val[i] = lat_wr[i] ? {msb_q, wdata_i} : latch_q[i];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      ttm_channel #(.W(CNT_W)) u_ch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (ch_tick[g]),
        .halt_i    (ctrl_q[0][C_HOLD]),
        .dual_i    (ctrl_q[g][C_DUAL]),
        .load_i    (load[g]),
        .load_val_i(load_val[g]),
        .latch_i   (latch_q[g]),
        .count_o   (count[g]),
        .expire_o  (expire[g])
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ctrl_q[g]  <= '0;
          latch_q[g] <= '1;
        end else begin
          if (ctl_wr[g]) ctrl_q[g]  <= wdata_i;
          if (lat_wr[g]) latch_q[g] <= {msb_q, wdata_i};
        end
      end

      a_r6_latch_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lat_wr[g] && !expire[g]) |=> !flag_q[g]);

      a_r10_unseen_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_rd[g] && flag_q[g] && !seen_q[g] && !lat_wr[g] && !gr_chg) |=> flag_q[g]);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      flag_d[i] = flag_q[i];
      if (lat_wr[i])              flag_d[i] = 1'b0;
      if (cnt_rd[i] && seen_q[i]) flag_d[i] = 1'b0;
      if (expire[i])              flag_d[i] = 1'b1;
      if (gr_chg)                 flag_d[i] = 1'b0;
      seen_d[i] = seen_q[i];
      if (st_rd)                  seen_d[i] = seen_q[i] | flag_q[i];
      if (expire[i])              seen_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      seen_q <= '0;
      msb_q  <= '0;
      lsb_q  <= '0;
    end else begin
      flag_q <= flag_d;
      seen_q <= seen_d;
      if (wr_en_i && addr_i[0] == 1'b0 && addr_i != 3'd0) msb_q <= wdata_i;
      for (int i = 0; i < NUM_CH; i++)
        if (cnt_rd[i]) lsb_q <= count[i][BYTE_W-1:0];
    end
  end

  assign irq_o = |(flag_q & ien);

  always_comb begin
    unique case (addr_i)
      3'd0:    rdata_o = '0;
      3'd1:    rdata_o = {irq_o, 4'b0, flag_q};
      3'd2:    rdata_o = count[0][CNT_W-1:BYTE_W];
      3'd4:    rdata_o = count[1][CNT_W-1:BYTE_W];
      3'd6:    rdata_o = count[2][CNT_W-1:BYTE_W];
      default: rdata_o = lsb_q;
    endcase
  end

  a_r7_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gr_chg |=> (flag_q == '0));

  a_r10_seen_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(expire & seen_q)) |=> (|(~seen_q & $past(expire))));
endmodule

// File: tb/sim_tri_interval_timer.sv
module sim_tri_interval_timer;
  logic       clk_i = 0, rst_ni = 0, wr_en_i = 0, rd_en_i = 0;
  logic [2:0] addr_i = 0, ext_tick_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;
  logic       irq_o;
  int checks = 0, errors = 0;
  logic [7:0] d;

  tri_interval_timer u0 (.*);

  always #2 clk_i = ~clk_i;

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk_i); wr_en_i = 1; addr_i = a; wdata_i = v;
    @(posedge clk_i); #1 wr_en_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk_i); rd_en_i = 1; addr_i = a;
    #1 v = rdata_o;
    @(posedge clk_i); #1 rd_en_i = 0;
  endtask

  task automatic pulse(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); ext_tick_i = 3'(1 << ch);
      @(posedge clk_i); #1 ext_tick_i = 0;
    end
  endtask

  task automatic t_reset();
    rd(3'd1, d); check("R1 status", d, 8'h00);
    rd(3'd0, d); check("R1 offset0", d, 8'h00);
    rd(3'd4, d); check("R1 cnt1 msb", d, 8'hFF);
    rd(3'd5, d); check("R1 cnt1 lsb", d, 8'hFF);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_word();
    wr(3'd1, 8'h00);              // ch1 ctrl, offset 0 -> ch2
    wr(3'd0, 8'h40);              // ch2: ext clock, word, irq enable
    wr(3'd6, 8'h00); wr(3'd7, 8'h03);
    pulse(2, 3);
    rd(3'd6, d); check("R5 cnt at zero msb", d, 8'h00);
    rd(3'd7, d); check("R5 cnt at zero lsb", d, 8'h00);
    rd(3'd1, d); check("R5 no early flag", d, 8'h00);
    pulse(2, 1);
    check("R8 irq on", irq_o, 1);
    rd(3'd1, d); check("R8 status", d, 8'h84);
    rd(3'd6, d); check("R5 reload msb", d, 8'h00);
    rd(3'd7, d); check("R5 reload lsb", d, 8'h03);
    rd(3'd1, d); check("R10 seen read clears", d, 8'h00);
    check("R8 irq off", irq_o, 0);
  endtask

  task automatic t_unseen();
    pulse(2, 4);
    rd(3'd6, d);
    rd(3'd1, d); check("R10 unseen flag kept", d, 8'h84);
    rd(3'd6, d);
    rd(3'd1, d); check("R10 cleared after status", d, 8'h00);
  endtask

  task automatic t_no_reload();
    wr(3'd0, 8'h50);              // ch2: bit4 set keeps counter on latch write
    pulse(2, 4);                  // count 3 -> timeout, flag set
    rd(3'd1, d); check("R6 flag before latch", d, 8'h84);
    wr(3'd6, 8'h00); wr(3'd7, 8'h10);
    rd(3'd1, d); check("R6 latch write clears flag", d, 8'h00);
    rd(3'd7, d);
    rd(3'd6, d); check("R6 no reload msb", d, 8'h00);
    rd(3'd7, d); check("R6 no reload lsb", d, 8'h03);
    pulse(2, 4);
    rd(3'd6, d);
    rd(3'd7, d); check("R6 new latch on timeout", d, 8'h10);
    wr(3'd7, 8'h10);
    check("R6 irq cleared", irq_o, 0);
  endtask

  task automatic t_dual();
    wr(3'd1, 8'h04);              // ch1: cascaded, ext clock
    wr(3'd4, 8'h01); wr(3'd5, 8'h02);
    rd(3'd4, d); check("R9 msb", d, 8'h01);
    pulse(1, 1);
    rd(3'd5, d); check("R9 coherent lsb", d, 8'h02);
    pulse(1, 4);
    rd(3'd4, d); check("R4 msb before timeout", d, 8'h00);
    rd(3'd5, d); check("R4 lsb before timeout", d, 8'h00);
    rd(3'd1, d); check("R4 no early flag", d, 8'h00);
    pulse(1, 1);
    rd(3'd1, d); check("R4 flag after 6 ticks", d, 8'h02);
    check("R8 masked irq", irq_o, 0);
    rd(3'd4, d); check("R4 msb reload", d, 8'h01);
    rd(3'd5, d); check("R4 lsb reload", d, 8'h02);
  endtask

  task automatic t_hold();
    pulse(2, 1);                  // ch2 0x0010 -> 0x000F
    wr(3'd1, 8'h05);              // ch1 bit0=1: offset 0 -> ch0
    pulse(1, 6);                  // ch1 times out again
    rd(3'd1, d); check("R2 routing pre", d, 8'h02);
    wr(3'd0, 8'h01);              // global hold
    rd(3'd1, d); check("R7 hold clears status", d, 8'h00);
    pulse(2, 3);
    rd(3'd6, d);
    rd(3'd7, d); check("R7 halted", d, 8'h0F);
    rd(3'd2, d); check("R2 ch0 untouched count", d, 8'hFF);
    wr(3'd0, 8'h00);
    rd(3'd6, d);
    rd(3'd7, d); check("R7 release reloads", d, 8'h10);
    rd(3'd4, d); check("R7 release reloads ch1", d, 8'h01);
  endtask

  task automatic t_clk();
    int n = 0;
    wr(3'd2, 8'h00); wr(3'd3, 8'h04);
    wr(3'd0, 8'h42);              // ch0 internal clock, irq enable
    while (!irq_o && n < 200) begin
      @(posedge clk_i); n++; #1;
    end
    checks++;
    if (n < 41 || n > 50) begin
      errors++;
      $display("FAIL R3 internal period: got %0d expected 41..50", n);
    end
    rd(3'd1, d); check("R8 ch0 status", d, 8'h81);
    wr(3'd0, 8'h40);              // back to ext: reload
    repeat (30) @(posedge clk_i);
    rd(3'd2, d); check("R3 ext ignores internal msb", d, 8'h00);
    rd(3'd3, d); check("R3 ext ignores internal lsb", d, 8'h04);
    rd(3'd1, d); check("R3 flag cleared", d, 8'h00);
    wr(3'd1, 8'h04);              // offset 0 -> ch2 again
    wr(3'd0, 8'h00);              // ch2 ctrl now 0: ch0 unaffected
    rd(3'd2, d);
    rd(3'd3, d); check("R2 ch0 not written", d, 8'h04);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    t_reset();
    t_word();
    t_unseen();
    t_no_reload();
    t_dual();
    t_hold();
    t_clk();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule